// File: doc/BRIEF.md
# Packed Halfword Register Bridge

The bridge fronts a bank of 16-bit lane configuration registers that are kept two to a 32-bit storage word. A requester names a lane, a page and a register number, and asks for a read or a write. The bridge turns the request into a word index. That index depends on the lane pair, on whether the lane is odd or even, on the lane's speed class and on the page group. The bridge then picks the correct halfword. A write is carried out as a read-modify-write of the whole word, so the partner register in the other half keeps its value. Combinations that the layout leaves unmapped are holes. Requests outside the legal lane or page range come back with an error flag.

Requests enter on a valid/ready channel and results leave on a second valid/ready channel. Only one request is in flight at a time. `req_ready` is high only while the bridge is idle. A result stays on the response channel, unchanged, until the requester takes it with `resp_ready`. A requester that stalls the response therefore stalls the request side too. `busy` is high from the cycle after a request is accepted until its response has been taken.

Top module: `lane_cfg_bridge`

## Requirements
- R1: After reset `req_ready` is 1, `busy` is 0 and `resp_valid` is 0, and every mapped register reads 0.
- R2: A request with lane above 13 or page above 11 completes with `resp_err`=1 and `resp_rdata`=0, and changes no stored register. All other requests complete with `resp_err`=0.
- R3: An even register number occupies bits 15:0 of its word and an odd one bits 31:16. A value written to a mapped register reads back unchanged.
- R4: Writing one register of an even/odd pair leaves its partner (register number XOR 1) with its previous value.
- R5: Pages 0 to 3 are mapped for every lane 0 to 13. An even lane and its odd neighbour share a region but hold separate registers.
- R6: Pages 4 to 7 are mapped only for lanes 8 and 12 and are holes for every other lane.
- R7: Pages 8 and 9 are mapped only for the slow lanes (0 to 7, 10, 11). Pages 10 and 11 are mapped only for the fast lanes (8, 9, 12, 13).
- R8: A read of a hole returns 0. A write to a hole completes normally and alters no register. All mapped (lane, page, register) triples hold distinct values.
- R9: A read of page 2, register 2 of any valid lane returns 0x001C, and page 2, register 3 returns 0x8393, whatever was written there.
- R10: While `busy` is 1, `req_ready` is 0 and requests are not taken. A held response keeps `resp_rdata` and `resp_err` stable until `resp_ready`. On the edge that takes the response the bridge returns to idle.
- R11: Counting from the accepting edge, `resp_valid` rises at the third edge for a write to a mapped register, and at the second edge for every other request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle and able to take a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_lane | input | 4 | Lane index |
| req_page | input | 4 | Page number |
| req_reg | input | 5 | Register number within the page |
| req_wdata | input | 16 | Write value |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Requester takes the response |
| resp_rdata | output | 16 | Read value; 0 for writes, holes and errors |
| resp_err | output | 1 | Request was outside the legal range |
| busy | output | 1 | A request is in progress |

## Verification
The hardest property to show from the ports is that no two mapped triples share storage. A second part of it is that no erroneous, hole or ignored request lands in some unrelated word through index wrap-around. The stimulus writes a distinct value to every legal lane, page and register. It then sends out-of-range writes whose raw index would fall on real words. It also holds a conflicting write on the request channel while the bridge is busy. Finally it reads the whole space back against a reference keyed by the logical triple rather than by any word offset.

// File: rtl/lane_cfg_pkg.sv
package lane_cfg_pkg;

  // words in the storage region shared by one even/odd lane pair
  localparam int unsigned PAIR_WORDS = 256;
  // word stride of one page
  localparam int unsigned PAGE_WORDS = 16;

  // page group boundaries
  localparam int unsigned PG_EXT_LO  = 4;
  localparam int unsigned PG_SLOW_LO = 8;
  localparam int unsigned PG_FAST_LO = 10;
  localparam int unsigned PG_END     = 12;

  // word offsets added per group
  localparam int unsigned ODD_GROUP_OFF = 64;
  localparam int unsigned EXT_OFF       = 64;
  localparam int unsigned SLOW_OFF      = 64;
  localparam int unsigned FAST_OFF      = 32;
  localparam int unsigned ODD_HIGH_OFF  = 32;

  // identifier stand-in values
  localparam int unsigned ID_PAGE = 2;
  localparam int unsigned ID_PAIR = 1;
  localparam logic [15:0] ID_LO   = 16'h001C;
  localparam logic [15:0] ID_HI   = 16'h8393;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RESP  = 2'd3
  } bridge_state_e;

endpackage

// File: rtl/lane_cfg_decode.sv
module lane_cfg_decode
  import lane_cfg_pkg::*;
#(
  parameter int LANES = 14,
  parameter int PAGES = 12,
  parameter int LANE_W = 4,
  parameter int PAGE_W = 4,
  parameter int PAIR_W = 4,
  parameter int IDX_W = 11,
  parameter logic [LANES-1:0] FAST_MASK = 14'h3300,
  parameter logic [LANES-1:0] EXT_MASK  = 14'h1100
) (
  input  logic [LANE_W-1:0] lane,
  input  logic [PAGE_W-1:0] page,
  input  logic [PAIR_W-1:0] reg_pair,
  output logic [IDX_W-1:0]  idx,
  output logic              hole,
  output logic              range_err
);

  localparam int PAIR_SHIFT = $clog2(PAIR_WORDS);
  localparam int PAGE_SHIFT = $clog2(PAGE_WORDS);

  logic             lane_ok;
  logic             is_fast;
  logic             is_ext;
  logic             odd_lane;
  logic [IDX_W-1:0] add;
  logic [IDX_W-1:0] base;

  assign lane_ok   = 32'(lane) < LANES;
  assign range_err = !lane_ok || (32'(page) >= PAGES);
  assign is_fast   = lane_ok && FAST_MASK[lane];
  assign is_ext    = lane_ok && EXT_MASK[lane];
  assign odd_lane  = lane[0];

  assign base = (IDX_W'(lane >> 1) << PAIR_SHIFT)
              + (IDX_W'(page) << PAGE_SHIFT)
              + IDX_W'(reg_pair);

  always_comb begin
    add  = '0;
    hole = 1'b1;
    if (32'(page) < PG_EXT_LO) begin
      hole = 1'b0;
      add  = odd_lane ? IDX_W'(ODD_GROUP_OFF) : '0;
    end else if (32'(page) < PG_SLOW_LO) begin
      if (is_ext) begin
        hole = 1'b0;
        add  = IDX_W'(EXT_OFF);
      end
    end else if (32'(page) < PG_FAST_LO) begin
      if (!is_fast) begin
        hole = 1'b0;
        add  = IDX_W'(SLOW_OFF) + (odd_lane ? IDX_W'(ODD_HIGH_OFF) : '0);
      end
    end else if (32'(page) < PG_END) begin
      if (is_fast) begin
        hole = 1'b0;
        add  = IDX_W'(FAST_OFF) + (odd_lane ? IDX_W'(ODD_HIGH_OFF) : '0);
      end
    end
  end

  assign idx = base + add;

endmodule

// File: rtl/lane_cfg_store.sv
module lane_cfg_store #(
  parameter int DEPTH = 1792,
  parameter int IDX_W = 11,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && (32'(wr_idx) < DEPTH)) begin
      mem[wr_idx] <= wr_word;
    end
  end

  assign rd_word = (32'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;

endmodule

// File: rtl/lane_cfg_merge.sv
module lane_cfg_merge
  import lane_cfg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [2*DATA_W-1:0] word,
  input  logic                odd_reg,
  input  logic                id_pair,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rd_val,
  output logic [2*DATA_W-1:0] merged
);

  logic [DATA_W-1:0] lo_half;
  logic [DATA_W-1:0] hi_half;

  assign lo_half = word[DATA_W-1:0];
  assign hi_half = word[2*DATA_W-1:DATA_W];

  always_comb begin
    if (id_pair) rd_val = odd_reg ? DATA_W'(ID_HI) : DATA_W'(ID_LO);
    else         rd_val = odd_reg ? hi_half : lo_half;
  end

  // the partner half is carried over from the word just read
  assign merged = odd_reg ? {wdata, lo_half} : {hi_half, wdata};

endmodule

// File: rtl/lane_cfg_bridge.sv
module lane_cfg_bridge
  import lane_cfg_pkg::*;
#(
  parameter int LANES = 14,
  parameter int PAGES = 12,
  parameter int REGS = 32,
  parameter int DATA_W = 16,
  parameter logic [LANES-1:0] FAST_MASK = 14'h3300,
  parameter logic [LANES-1:0] EXT_MASK  = 14'h1100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [3:0]        req_lane,
  input  logic [3:0]        req_page,
  input  logic [4:0]        req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              resp_err,
  output logic              busy
);

  localparam int LANE_W = 4;
  localparam int PAGE_W = 4;
  localparam int REG_W  = $clog2(REGS);
  localparam int PAIR_W = REG_W - 1;
  localparam int WORD_W = 2 * DATA_W;
  localparam int DEPTH  = ((LANES + 1) / 2) * PAIR_WORDS;
  localparam int IDX_W  = $clog2(DEPTH);

  bridge_state_e     state;
  logic              cap_write;
  logic [LANE_W-1:0] cap_lane;
  logic [PAGE_W-1:0] cap_page;
  logic [REG_W-1:0]  cap_reg;
  logic [DATA_W-1:0] cap_wdata;
  logic [WORD_W-1:0] wr_word_q;
  logic [DATA_W-1:0] resp_data_q;
  logic              resp_err_q;

  logic [IDX_W-1:0]  dec_idx;
  logic              dec_hole;
  logic              dec_err;
  logic [WORD_W-1:0] st_word;
  logic [DATA_W-1:0] rd_val;
  logic [WORD_W-1:0] mrg_word;
  logic              id_pair;

  lane_cfg_decode #(
    .LANES(LANES), .PAGES(PAGES), .LANE_W(LANE_W), .PAGE_W(PAGE_W),
    .PAIR_W(PAIR_W), .IDX_W(IDX_W), .FAST_MASK(FAST_MASK), .EXT_MASK(EXT_MASK)
  ) u_decode (
    .lane(cap_lane),
    .page(cap_page),
    .reg_pair(cap_reg[REG_W-1:1]),
    .idx(dec_idx),
    .hole(dec_hole),
    .range_err(dec_err)
  );

  lane_cfg_store #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .WORD_W(WORD_W)
  ) u_store (
    .clk(clk),
    .rst_n(rst_n),
    .rd_idx(dec_idx),
    .rd_word(st_word),
    .wr_en(state == ST_WRITE),
    .wr_idx(dec_idx),
    .wr_word(wr_word_q)
  );

  assign id_pair = (cap_page == PAGE_W'(ID_PAGE)) && (cap_reg[REG_W-1:1] == PAIR_W'(ID_PAIR));

  lane_cfg_merge #(
    .DATA_W(DATA_W)
  ) u_merge (
    .word(st_word),
    .odd_reg(cap_reg[0]),
    .id_pair(id_pair),
    .wdata(cap_wdata),
    .rd_val(rd_val),
    .merged(mrg_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cap_write   <= 1'b0;
      cap_lane    <= '0;
      cap_page    <= '0;
      cap_reg     <= '0;
      cap_wdata   <= '0;
      wr_word_q   <= '0;
      resp_data_q <= '0;
      resp_err_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cap_write   <= req_write;
            cap_lane    <= req_lane;
            cap_page    <= req_page;
            cap_reg     <= req_reg;
            cap_wdata   <= req_wdata;
            resp_err_q  <= 1'b0;
            resp_data_q <= '0;
            state       <= ST_READ;
          end
        end
        ST_READ: begin
          if (dec_err) begin
            resp_err_q  <= 1'b1;
            resp_data_q <= '0;
            state       <= ST_RESP;
          end else if (dec_hole) begin
            resp_data_q <= '0;
            state       <= ST_RESP;
          end else if (cap_write) begin
            wr_word_q   <= mrg_word;
            resp_data_q <= '0;
            state       <= ST_WRITE;
          end else begin
            resp_data_q <= rd_val;
            state       <= ST_RESP;
          end
        end
        ST_WRITE: state <= ST_RESP;
        ST_RESP: begin
          if (resp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign busy       = (state != ST_IDLE);
  assign resp_valid = (state == ST_RESP);
  assign resp_rdata = resp_data_q;
  assign resp_err   = resp_err_q;

endmodule

// File: rtl/lane_cfg_bridge_chk.sv
module lane_cfg_bridge_chk #(
  parameter int LANES = 14,
  parameter int PAGES = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [3:0]        req_lane,
  input logic [3:0]        req_page,
  input logic [4:0]        req_reg,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic [DATA_W-1:0] resp_rdata,
  input logic              resp_err,
  input logic              busy
);

  logic       c_write;
  logic [3:0] c_lane;
  logic [3:0] c_page;
  logic [4:0] c_reg;
  logic       c_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_write <= 1'b0;
      c_lane  <= '0;
      c_page  <= '0;
      c_reg   <= '0;
    end else if (req_valid && req_ready) begin
      c_write <= req_write;
      c_lane  <= req_lane;
      c_page  <= req_page;
      c_reg   <= req_reg;
    end
  end

  assign c_bad = (32'(c_lane) >= LANES) || (32'(c_page) >= PAGES);

  assert_hold_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_rdata) && $stable(resp_err));

  assert_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready);

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_ready |=> req_ready && !busy && !resp_valid);

  assert_no_early_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !resp_valid);

  assert_err_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_err == c_bad));

  assert_err_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_err |-> resp_rdata == '0);

  assert_id_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !c_write && !c_bad && c_page == 4'd2 && c_reg == 5'd2 |-> resp_rdata == 16'h001C);

  assert_id_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !c_write && !c_bad && c_page == 4'd2 && c_reg == 5'd3 |-> resp_rdata == 16'h8393);

endmodule

bind lane_cfg_bridge lane_cfg_bridge_chk #(.LANES(LANES), .PAGES(PAGES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_lane(req_lane), .req_page(req_page), .req_reg(req_reg),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_rdata(resp_rdata),
  .resp_err(resp_err), .busy(busy)
);

// File: tb/lane_cfg_bridge_test.sv
`timescale 1ns/1ps
module lane_cfg_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_lane = '0;
  logic [3:0]  req_page = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b0;
  logic [15:0] resp_rdata;
  logic        resp_err;
  logic        busy;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] mdl [int];

  always #10 clk = ~clk;

  lane_cfg_bridge uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_lane(req_lane), .req_page(req_page), .req_reg(req_reg),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_rdata(resp_rdata), .resp_err(resp_err), .busy(busy)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_bad(int l, int p);
    return (l > 13) || (p > 11);
  endfunction

  function automatic bit is_slow(int l);
    return (l < 8) || (l == 10) || (l == 11);
  endfunction

  function automatic bit is_mapped(int l, int p);
    if (is_bad(l, p)) return 1'b0;
    if (p < 4) return 1'b1;
    if (p < 8) return (l == 8) || (l == 12);
    if (p < 10) return is_slow(l);
    return !is_slow(l);
  endfunction

  function automatic int key_of(int l, int p, int r);
    return l * 512 + p * 32 + r;
  endfunction

  function automatic logic [15:0] model_read(int l, int p, int r);
    if (!is_mapped(l, p)) return 16'h0000;
    if (p == 2 && r == 2) return 16'h001C;
    if (p == 2 && r == 3) return 16'h8393;
    if (mdl.exists(key_of(l, p, r))) return mdl[key_of(l, p, r)];
    return 16'h0000;
  endfunction

  function automatic string auto_tag(int l, int p, int r);
    if (is_bad(l, p)) return "R2";
    if (!is_mapped(l, p)) return "R8";
    if (p == 2 && (r == 2 || r == 3)) return "R9";
    if (p < 4) return "R5";
    if (p < 8) return "R6";
    return "R7";
  endfunction

  // one request, checked on every falling edge until the bridge is idle again
  task automatic do_req(bit wr, int l, int p, int r, logic [15:0] wd,
                        int hold, bit ghost, string tag);
    bit e = is_bad(l, p);
    bit m = is_mapped(l, p);
    logic [15:0] exp = wr ? 16'h0000 : model_read(l, p, r);
    string t = (tag == "") ? auto_tag(l, p, r) : tag;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_lane  = 4'(l);
    req_page  = 4'(p);
    req_reg   = 5'(r);
    req_wdata = wd;
    @(negedge clk);
    if (ghost) begin
      req_write = 1'b1;
      req_lane  = 4'd0;
      req_page  = 4'd0;
      req_reg   = 5'd5;
      req_wdata = 16'hDEAD;
    end else begin
      req_valid = 1'b0;
    end
    chk(busy == 1'b1, "R10", "busy after accept", int'(busy), 1);
    chk(req_ready == 1'b0, "R10", "ready while busy", int'(req_ready), 0);
    chk(resp_valid == 1'b0, "R11", "resp one edge after accept", int'(resp_valid), 0);
    if (wr && m) begin
      @(negedge clk);
      chk(resp_valid == 1'b0, "R11", "resp during write phase", int'(resp_valid), 0);
      chk(busy == 1'b1, "R10", "busy during write phase", int'(busy), 1);
    end
    @(negedge clk);
    chk(resp_valid == 1'b1, "R11", "resp present", int'(resp_valid), 1);
    chk(resp_rdata == exp, t, "rdata", int'(resp_rdata), int'(exp));
    chk(resp_err == e, "R2", "err flag", int'(resp_err), int'(e));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(resp_valid == 1'b1, "R10", "resp held", int'(resp_valid), 1);
      chk(resp_rdata == exp, "R10", "rdata held", int'(resp_rdata), int'(exp));
    end
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    req_valid  = 1'b0;
    chk(resp_valid == 1'b0, "R10", "resp dropped", int'(resp_valid), 0);
    chk(busy == 1'b0, "R10", "idle after take", int'(busy), 0);
    chk(req_ready == 1'b1, "R10", "ready after take", int'(req_ready), 1);
    if (wr && m) mdl[key_of(l, p, r)] = wd;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(resp_valid == 1'b0, "R1", "resp after reset", int'(resp_valid), 0);
    do_req(1'b0, 0, 0, 0, 16'h0, 0, 1'b0, "R1");
    do_req(1'b0, 13, 11, 31, 16'h0, 0, 1'b0, "R1");

    // halves and partner preservation
    do_req(1'b1, 3, 1, 6, 16'h1234, 0, 1'b0, "R3");
    do_req(1'b1, 3, 1, 7, 16'hABCD, 0, 1'b0, "R3");
    do_req(1'b0, 3, 1, 6, 16'h0, 0, 1'b0, "R4");
    do_req(1'b0, 3, 1, 7, 16'h0, 0, 1'b0, "R3");
    do_req(1'b1, 3, 1, 6, 16'h5A5A, 0, 1'b0, "R3");
    do_req(1'b0, 3, 1, 7, 16'h0, 0, 1'b0, "R4");

    // even/odd lane neighbours
    do_req(1'b1, 0, 0, 0, 16'h0F0F, 0, 1'b0, "R5");
    do_req(1'b0, 1, 0, 0, 16'h0, 0, 1'b0, "R5");
    do_req(1'b1, 1, 0, 0, 16'hF00F, 0, 1'b0, "R5");
    do_req(1'b0, 0, 0, 0, 16'h0, 0, 1'b0, "R5");

    // identifier stand-ins ignore stored data
    do_req(1'b1, 5, 2, 2, 16'h7777, 0, 1'b0, "R9");
    do_req(1'b1, 5, 2, 3, 16'h6666, 0, 1'b0, "R9");
    do_req(1'b0, 5, 2, 2, 16'h0, 0, 1'b0, "R9");
    do_req(1'b0, 5, 2, 3, 16'h0, 0, 1'b0, "R9");

    // fill the whole space, holes included
    for (int l = 0; l < 14; l++)
      for (int p = 0; p < 12; p++)
        for (int r = 0; r < 32; r++)
          do_req(1'b1, l, p, r, 16'((l * 384 + p * 32 + r) ^ 16'hA5C3), 0, 1'b0, "");

    // out-of-range requests whose raw index could land on real words
    do_req(1'b1, 14, 0, 0, 16'hBAD0, 0, 1'b0, "R2");
    do_req(1'b1, 15, 3, 9, 16'hBAD1, 0, 1'b0, "R2");
    do_req(1'b1, 0, 12, 0, 16'hBAD2, 0, 1'b0, "R2");
    do_req(1'b1, 9, 15, 31, 16'hBAD3, 0, 1'b0, "R2");
    do_req(1'b0, 14, 2, 2, 16'h0, 0, 1'b0, "R2");
    do_req(1'b0, 1, 13, 4, 16'h0, 0, 1'b0, "R2");

    // back-pressure and a request held high while busy
    do_req(1'b0, 8, 5, 10, 16'h0, 3, 1'b0, "R10");
    do_req(1'b1, 12, 10, 4, 16'hC0DE, 4, 1'b1, "R10");
    do_req(1'b0, 0, 0, 5, 16'h0, 2, 1'b1, "R10");
    do_req(1'b0, 12, 10, 4, 16'h0, 0, 1'b0, "R3");

    // read everything back
    for (int l = 0; l < 14; l++)
      for (int p = 0; p < 12; p++)
        for (int r = 0; r < 32; r++)
          do_req(1'b0, l, p, r, 16'h0, 0, 1'b0, "");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule